// File: doc/BRIEF.md
# Dual-Slope PWM Timer

An 8-bit timer that counts up from 0 to 255 and back down to 0, one step per timer tick, and drives one output pin with a centre-aligned pulse-width-modulated waveform. The timer tick is a clock enable taken from a free-running prescaler. The prescaler divides the system clock by 1, 8, 64, 256 or 1024. One full up/down period lasts 510 ticks, so the output runs at f_clk / (N × 510).

The duty cycle comes from a compare value. Software writes that value into a holding buffer. The active copy takes the buffer only when the count reaches its top, so a write never cuts a period short. The pin goes low when the rising count meets the compare value and goes high when the falling count meets it. The two end values are forced: the count arriving at 0 or at 255 sets the level directly, with no match involved. This keeps the waveform symmetric and makes a compare value of 0 or 255 give a flat line. A polarity input inverts the pin. Two sticky flags record the bottom turn and each compare hit, and a write-one pulse clears them.

Top module: `pwm_phase_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the count goes to 0, the direction to up, and the prescaler count to 0. The compare buffer, the active compare value and both flags go to 0. `pwm` then shows the idle level: 0 with `invert`=0 and 1 with `invert`=1.
- R2: `div_sel` code 1, 2, 3, 4 or 5 gives one tick every 1, 8, 64, 256 or 1024 enabled cycles, the first tick landing on the N-th enabled cycle after reset. Codes 0, 6 and 7, or `run_en`=0, give no ticks and freeze the prescaler count, the counter, the direction and the output level.
- R3: Each tick moves `count` by exactly one. It rises from 0 to 255, then falls back to 0, then rises again, so one full period is 510 ticks.
- R4: A `cmp_wr` pulse stores `cmp_data` in the buffer only. The active compare value C takes the buffer content, as held before that edge, on the tick where the count arrives at 255. Until that tick the output follows the old C.
- R5: After each tick, with `invert`=0, `pwm` is 1 exactly when the count is below C (direction up) or is at most C (direction down). The direction becomes down on reaching 255 and up on reaching 0. `pwm` is therefore high for 2·C of every 510 ticks.
- R6: With C=0 the non-inverted output stays 0 for good. With C=255 it stays 1 for good.
- R7: With no compare match involved, the level is forced to (C≠0) when the count arrives at 0 and to (C=255) when it arrives at 255. A change of C away from 255 therefore takes effect at the top.
- R8: With `invert`=1, `pwm` is the complement of the non-inverted level in every cycle, including the flat cases. A change of `invert` shows in the same cycle.
- R9: `ovf_flag` sets on the tick where the count arrives at 0 and stays set until a cycle with `flag_clr[0]`=1. If a set and a clear fall in the same cycle, the set wins.
- R10: `cmp_flag` sets on every tick where the new count equals C, using the C in force after that tick. It is cleared by `flag_clr[1]`=1, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 3 | Prescale code: 1=/1, 2=/8, 3=/64, 4=/256, 5=/1024, others stop |
| run_en | input | 1 | Timer enable; 0 freezes the prescaler and counter |
| invert | input | 1 | Output polarity, 1 inverts the pin |
| cmp_wr | input | 1 | Write strobe for the compare buffer |
| cmp_data | input | 8 | Compare value to buffer |
| count | output | 8 | Current timer count |
| pwm | output | 1 | PWM output pin |
| flag_clr | input | 2 | Write-one clear: bit 0 overflow flag, bit 1 compare flag |
| ovf_flag | output | 1 | Sticky bottom-reached flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The hardest situation to reach from the ports is a compare change that crosses the top of the count. A value of 255 is replaced by a lower one, the new value takes over at 255, and the pin must drop there with no match. A related case is a buffered write made in the middle of the falling slope, which must leave the current period alone. A directed sequence places these writes at known tick numbers and checks the pin at counts on either side of the old and new thresholds. A long random run follows. It biases its writes toward 0, 1, 254 and 255, switches polarity and prescale code at random, and lets flag clears collide with flag sets. A cycle-level model in the bench checks every cycle of that run.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

   localparam int unsigned NUM_DIV = 5;

   localparam int unsigned FLG_OVF = 0;
   localparam int unsigned FLG_CMP = 1;
   localparam int unsigned FLG_N   = 2;

   typedef enum logic [2:0] {
      PS_OFF     = 3'd0,
      PS_DIV1    = 3'd1,
      PS_DIV8    = 3'd2,
      PS_DIV64   = 3'd3,
      PS_DIV256  = 3'd4,
      PS_DIV1024 = 3'd5
   } div_sel_e;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_tmr_pkg::*;
#(
   parameter int unsigned PRE_W = 10,
   parameter int unsigned SH_B  = 3,
   parameter int unsigned SH_C  = 6,
   parameter int unsigned SH_D  = 8,
   parameter int unsigned SH_E  = 10
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       run_en,
   input  logic [2:0] sel,
   output logic       tick
);

   localparam int unsigned SH_TAB [NUM_DIV] = '{0, SH_B, SH_C, SH_D, SH_E};

   if (SH_E > PRE_W) begin : g_bad_width
      $error("pwm_prescaler: PRE_W narrower than largest tap");
   end
   if (!(SH_B > 0 && SH_B < SH_C && SH_C < SH_D && SH_D < SH_E)) begin : g_bad_order
      $error("pwm_prescaler: tap shifts must be positive and ascending");
   end

   logic [PRE_W-1:0]   pc_q;
   logic [NUM_DIV-1:0] tap_hit;
   logic               sel_ok;
   logic               hit;

   for (genvar g = 0; g < NUM_DIV; g++) begin : g_tap
      if (SH_TAB[g] == 0) begin : g_every
         assign tap_hit[g] = 1'b1;
      end else begin : g_mask
         assign tap_hit[g] = &pc_q[SH_TAB[g]-1:0];
      end
   end

   always_comb begin
      sel_ok = 1'b1;
      hit    = 1'b0;
      case (sel)
         PS_DIV1:    hit = tap_hit[0];
         PS_DIV8:    hit = tap_hit[1];
         PS_DIV64:   hit = tap_hit[2];
         PS_DIV256:  hit = tap_hit[3];
         PS_DIV1024: hit = tap_hit[4];
         default:    sel_ok = 1'b0;
      endcase
   end

   assign tick = run_en && sel_ok && hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= '0;
      end else if (run_en && sel_ok) begin
         pc_q <= pc_q + 1'b1;
      end
   end

   // R2
   pre_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !run_en |=> $stable(pc_q));

   // R2
   div1_tick_chk: assert property (@(posedge clk) disable iff (rst)
      (run_en && sel == PS_DIV1) |-> tick);

endmodule

// File: rtl/pwm_updown.sv
module pwm_updown #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             up,
   output logic [CNT_W-1:0] nxt_cnt,
   output logic             nxt_up
);

   localparam logic [CNT_W-1:0] TOP = '1;
   localparam logic [CNT_W-1:0] BOT = '0;

   logic [CNT_W-1:0] cnt_q;
   logic             up_q;
   logic [CNT_W-1:0] inc;
   logic [CNT_W-1:0] dec;

   always_comb begin
      inc     = cnt_q + 1'b1;
      dec     = cnt_q - 1'b1;
      nxt_cnt = cnt_q;
      nxt_up  = up_q;
      if (tick) begin
         if (up_q) begin
            nxt_cnt = inc;
            nxt_up  = (inc != TOP);
         end else begin
            nxt_cnt = dec;
            nxt_up  = (dec == BOT);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= BOT;
         up_q  <= 1'b1;
      end else begin
         cnt_q <= nxt_cnt;
         up_q  <= nxt_up;
      end
   end

   assign cnt = cnt_q;
   assign up  = up_q;

   // R3
   step_one_chk: assert property (@(posedge clk) disable iff (rst)
      tick |=> (cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == $past(cnt_q) - 1'b1));

   // R2
   cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(cnt_q) && $stable(up_q));

   // R3
   top_turn_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == TOP) |-> !up_q);

   // R3
   bot_turn_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt_q == BOT) |-> up_q);

endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] nxt_cnt,
   input  logic             nxt_up,
   output logic [CNT_W-1:0] act,
   output logic [CNT_W-1:0] act_nxt,
   output logic             level
);

   localparam logic [CNT_W-1:0] TOP = '1;
   localparam logic [CNT_W-1:0] BOT = '0;

   logic [CNT_W-1:0] buf_q;
   logic [CNT_W-1:0] act_q;
   logic             lvl_q;
   logic             lvl_nxt;

   always_comb begin
      act_nxt = act_q;
      if (tick && nxt_cnt == TOP) begin
         act_nxt = buf_q;
      end
      lvl_nxt = lvl_q;
      if (tick) begin
         if (nxt_cnt == BOT) begin
            lvl_nxt = (act_nxt != BOT);
         end else if (nxt_cnt == TOP) begin
            lvl_nxt = (act_nxt == TOP);
         end else if (nxt_cnt == act_nxt) begin
            lvl_nxt = !nxt_up;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         buf_q <= BOT;
         act_q <= BOT;
         lvl_q <= 1'b0;
      end else begin
         if (wr) begin
            buf_q <= wdata;
         end
         act_q <= act_nxt;
         lvl_q <= lvl_nxt;
      end
   end

   assign act   = act_q;
   assign level = lvl_q;

   // R4
   load_at_top_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(act_q) |-> (cnt == TOP));

   // R7
   bot_force_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt == BOT) |-> (lvl_q == (act_q != BOT)));

   // R7
   top_force_chk: assert property (@(posedge clk) disable iff (rst)
      (cnt == TOP) |-> (lvl_q == (act_q == TOP)));

   // R6
   zero_low_chk: assert property (@(posedge clk) disable iff (rst)
      (act_q == BOT) |-> !lvl_q);

   // R6
   full_high_chk: assert property (@(posedge clk) disable iff (rst)
      (act_q == TOP) |-> lvl_q);

endmodule

// File: rtl/pwm_flags.sv
module pwm_flags
   import pwm_tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] act,
   input  logic [CNT_W-1:0] nxt_cnt,
   input  logic [CNT_W-1:0] act_nxt,
   input  logic [FLG_N-1:0] clr,
   output logic             ovf,
   output logic             cmp
);

   logic [FLG_N-1:0] set;
   logic [FLG_N-1:0] flg_q;

   always_comb begin
      set          = '0;
      set[FLG_OVF] = tick && (nxt_cnt == '0);
      set[FLG_CMP] = tick && (nxt_cnt == act_nxt);
   end

   for (genvar f = 0; f < FLG_N; f++) begin : g_flag
      always_ff @(posedge clk) begin
         if (rst) begin
            flg_q[f] <= 1'b0;
         end else if (set[f]) begin
            flg_q[f] <= 1'b1;
         end else if (clr[f]) begin
            flg_q[f] <= 1'b0;
         end
      end
   end

   assign ovf = flg_q[FLG_OVF];
   assign cmp = flg_q[FLG_CMP];

   // R9
   ovf_at_bottom_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flg_q[FLG_OVF]) |-> (cnt == '0));

   // R10
   cmp_on_match_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(flg_q[FLG_CMP]) |-> (cnt == act));

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (flg_q[FLG_OVF] && !clr[FLG_OVF]) |=> flg_q[FLG_OVF]);

endmodule

// File: rtl/pwm_phase_timer.sv
module pwm_phase_timer
   import pwm_tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned PRE_W = 10
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [2:0]       div_sel,
   input  logic             run_en,
   input  logic             invert,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] cmp_data,
   output logic [CNT_W-1:0] count,
   output logic             pwm,
   input  logic [1:0]       flag_clr,
   output logic             ovf_flag,
   output logic             cmp_flag
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("pwm_phase_timer: CNT_W must be at least 2");
   end

   logic             tick;
   logic [CNT_W-1:0] cnt;
   logic             up;
   logic [CNT_W-1:0] nxt_cnt;
   logic             nxt_up;
   logic [CNT_W-1:0] act;
   logic [CNT_W-1:0] act_nxt;
   logic             level;

   pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .run_en (run_en),
      .sel    (div_sel),
      .tick   (tick)
   );

   pwm_updown #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .cnt     (cnt),
      .up      (up),
      .nxt_cnt (nxt_cnt),
      .nxt_up  (nxt_up)
   );

   pwm_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .wr      (cmp_wr),
      .wdata   (cmp_data),
      .cnt     (cnt),
      .nxt_cnt (nxt_cnt),
      .nxt_up  (nxt_up),
      .act     (act),
      .act_nxt (act_nxt),
      .level   (level)
   );

   pwm_flags #(.CNT_W(CNT_W)) u_flg (
      .clk     (clk),
      .rst     (rst),
      .tick    (tick),
      .cnt     (cnt),
      .act     (act),
      .nxt_cnt (nxt_cnt),
      .act_nxt (act_nxt),
      .clr     (flag_clr),
      .ovf     (ovf_flag),
      .cmp     (cmp_flag)
   );

   assign count = cnt;
   assign pwm   = level ^ invert;

   // R5
   dir_level_chk: assert property (@(posedge clk) disable iff (rst)
      (up && cnt >= act) |-> !level);

endmodule

// File: tb/test_pwm_phase_timer.sv
`timescale 1ns/1ps
module test_pwm_phase_timer;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] div_sel = 3'd1;
   logic       run_en = 1'b0;
   logic       invert = 1'b0;
   logic       cmp_wr = 1'b0;
   logic [7:0] cmp_data = 8'd0;
   logic [1:0] flag_clr = 2'b00;
   logic [7:0] count;
   logic       pwm;
   logic       ovf_flag;
   logic       cmp_flag;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   pwm_phase_timer i_pwm_phase_timer (
      .clk      (clk),
      .rst      (rst),
      .div_sel  (div_sel),
      .run_en   (run_en),
      .invert   (invert),
      .cmp_wr   (cmp_wr),
      .cmp_data (cmp_data),
      .count    (count),
      .pwm      (pwm),
      .flag_clr (flag_clr),
      .ovf_flag (ovf_flag),
      .cmp_flag (cmp_flag)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int div_shift(input logic [2:0] s);
      case (s)
         3'd1: return 0;
         3'd2: return 3;
         3'd3: return 6;
         3'd4: return 8;
         3'd5: return 10;
         default: return -1;
      endcase
   endfunction

   function automatic bit exp_level(input bit dir_up, input logic [7:0] c, input logic [7:0] k);
      return dir_up ? (c < k) : (c <= k);
   endfunction

   // cycle-level reference built from the requirements
   logic [9:0] m_pc;
   logic [7:0] m_cnt, m_buf, m_act;
   logic       m_up, m_ovf, m_cmp;

   always @(posedge clk) begin : model
      int         sh;
      logic       tk;
      logic [7:0] nc;
      logic       nu;
      logic [7:0] na;
      logic [9:0] mk;
      sh = div_shift(div_sel);
      tk = 1'b0;
      if (rst) begin
         m_pc <= '0; m_cnt <= '0; m_up <= 1'b1; m_buf <= '0;
         m_act <= '0; m_ovf <= 1'b0; m_cmp <= 1'b0;
      end else begin
         if (run_en && sh >= 0) begin
            mk = (10'd1 << sh) - 10'd1;
            tk = ((m_pc & mk) == mk);
            m_pc <= m_pc + 10'd1;
         end
         nc = m_cnt;
         nu = m_up;
         if (tk) begin
            if (m_up) begin nc = m_cnt + 8'd1; nu = (nc != 8'hFF); end
            else      begin nc = m_cnt - 8'd1; nu = (nc == 8'h00); end
         end
         na = (tk && nc == 8'hFF) ? m_buf : m_act;
         m_cnt <= nc;
         m_up  <= nu;
         m_act <= na;
         if (cmp_wr) m_buf <= cmp_data;
         m_ovf <= (tk && nc == 8'h00) ? 1'b1 : (flag_clr[0] ? 1'b0 : m_ovf);
         m_cmp <= (tk && nc == na)    ? 1'b1 : (flag_clr[1] ? 1'b0 : m_cmp);
      end
   end

   always @(negedge clk) begin
      if (!rst && !done) begin
         bit ep;
         ep = invert ^ exp_level(m_up, m_cnt, m_act);
         chk(count == m_cnt, "R3 count per cycle", count, m_cnt);
         chk(pwm == ep, "R5 pin level per cycle", pwm, ep);
         chk(ovf_flag == m_ovf, "R9 ovf flag per cycle", ovf_flag, m_ovf);
         chk(cmp_flag == m_cmp, "R10 cmp flag per cycle", cmp_flag, m_cmp);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         bad++;
         total++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart(input logic [2:0] sel);
      @(negedge clk);
      rst = 1'b1;
      wait_cyc(2);
      div_sel  = sel;
      run_en   = 1'b1;
      invert   = 1'b0;
      cmp_wr   = 1'b0;
      flag_clr = 2'b00;
      rst      = 1'b0;
   endtask

   task automatic write_cmp(input logic [7:0] v);
      cmp_wr   = 1'b1;
      cmp_data = v;
      @(negedge clk);
      cmp_wr   = 1'b0;
   endtask

   task automatic measure(input int n, output int hi);
      hi = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm) hi++;
      end
   endtask

   initial begin
      int hi;
      int unsigned seed_v;
      seed_v = $urandom(32'd7717);

      // R1 reset state
      wait_cyc(3);
      chk(count == 8'd0, "R1 count at reset", count, 0);
      chk(pwm == 1'b0, "R1 idle level non-inverted", pwm, 0);
      chk(ovf_flag == 1'b0 && cmp_flag == 1'b0, "R1 flags at reset", {ovf_flag, cmp_flag}, 0);
      invert = 1'b1;
      @(negedge clk);
      chk(pwm == 1'b1, "R1 R8 idle level inverted", pwm, 1);
      invert = 1'b0;

      // R2 prescaler
      restart(3'd2);
      wait_cyc(40);
      chk(count == 8'd5, "R2 divide by 8", count, 5);
      run_en = 1'b0;
      wait_cyc(20);
      chk(count == 8'd5, "R2 run_en low freezes", count, 5);
      run_en = 1'b1;
      div_sel = 3'd0;
      wait_cyc(20);
      chk(count == 8'd5, "R2 code 0 stops", count, 5);
      div_sel = 3'd7;
      wait_cyc(9);
      chk(count == 8'd5, "R2 code 7 stops", count, 5);
      div_sel = 3'd1;
      wait_cyc(3);
      chk(count == 8'd8, "R2 divide by 1", count, 8);
      restart(3'd5);
      wait_cyc(1023);
      chk(count == 8'd0, "R2 divide by 1024 before tick", count, 0);
      wait_cyc(1);
      chk(count == 8'd1, "R2 divide by 1024 first tick", count, 1);

      // R6 compare value 0
      restart(3'd1);
      measure(1100, hi);
      chk(hi == 0, "R6 compare 0 stays low", hi, 0);

      // R4 R6 R7 compare value 255 then a lower value
      restart(3'd1);
      write_cmp(8'hFF);
      wait_cyc(253);
      chk(count == 8'd254 && pwm == 1'b0, "R4 buffered value not yet active", pwm, 0);
      wait_cyc(1);
      chk(count == 8'd255 && pwm == 1'b1, "R7 level forced at top for 255", pwm, 1);
      write_cmp(8'd100);
      measure(508, hi);
      chk(hi == 508, "R6 compare 255 stays high", hi, 508);
      wait_cyc(1);
      chk(count == 8'd255 && pwm == 1'b0, "R7 drop at top leaving 255", pwm, 0);
      measure(510, hi);
      chk(hi == 200, "R5 duty 2C for C=100", hi, 200);
      invert = 1'b1;
      measure(510, hi);
      chk(hi == 310, "R8 inverted duty", hi, 310);
      invert = 1'b0;
      write_cmp(8'd50);
      wait_cyc(134);
      chk(count == 8'd120 && pwm == 1'b0, "R5 falling side above C", pwm, 0);
      wait_cyc(30);
      chk(count == 8'd90 && pwm == 1'b1, "R4 old C kept mid period", pwm, 1);
      wait_cyc(345);
      chk(count == 8'd255 && pwm == 1'b0, "R4 reached top", count, 255);
      wait_cyc(180);
      chk(count == 8'd75 && pwm == 1'b0, "R4 new C after top", pwm, 0);
      wait_cyc(40);
      chk(count == 8'd35 && pwm == 1'b1, "R5 falling side below C", pwm, 1);

      // R3 R9 R10 period and flags
      restart(3'd1);
      wait_cyc(509);
      chk(count == 8'd1 && ovf_flag == 1'b0, "R3 R9 one tick before bottom", ovf_flag, 0);
      chk(cmp_flag == 1'b0, "R10 no match before bottom", cmp_flag, 0);
      wait_cyc(1);
      chk(count == 8'd0 && ovf_flag == 1'b1, "R3 R9 bottom after 510 ticks", ovf_flag, 1);
      chk(cmp_flag == 1'b1, "R10 match at C=0", cmp_flag, 1);
      flag_clr = 2'b01;
      wait_cyc(1);
      flag_clr = 2'b00;
      chk(ovf_flag == 1'b0 && cmp_flag == 1'b1, "R9 clear bit 0 only", {ovf_flag, cmp_flag}, 1);
      flag_clr = 2'b10;
      wait_cyc(1);
      flag_clr = 2'b00;
      chk(cmp_flag == 1'b0, "R10 clear bit 1", cmp_flag, 0);
      wait_cyc(507);
      flag_clr = 2'b11;
      wait_cyc(1);
      flag_clr = 2'b00;
      chk(count == 8'd0 && ovf_flag == 1'b1, "R9 set beats clear", ovf_flag, 1);
      chk(cmp_flag == 1'b1, "R10 set beats clear", cmp_flag, 1);

      // random run checked by the per-cycle reference
      restart(3'd1);
      for (int s = 0; s < 180; s++) begin
         int r;
         int len;
         r = $urandom_range(99, 0);
         div_sel = (r < 75) ? 3'd1 : ((r < 92) ? 3'd2 : 3'($urandom_range(7, 0)));
         run_en = ($urandom_range(9, 0) != 0);
         invert = 1'($urandom_range(1, 0));
         len = $urandom_range(400, 40);
         for (int c = 0; c < len; c++) begin
            int v;
            v = $urandom_range(9, 0);
            cmp_wr = ($urandom_range(63, 0) == 0);
            cmp_data = (v == 0) ? 8'h00 : (v == 1) ? 8'hFF : (v == 2) ? 8'hFE :
                       (v == 3) ? 8'h01 : 8'($urandom_range(255, 0));
            flag_clr = ($urandom_range(15, 0) == 0) ? 2'($urandom_range(3, 0)) : 2'b00;
            @(negedge clk);
         end
      end
      cmp_wr = 1'b0;
      flag_clr = 2'b00;
      wait_cyc(2);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule